// File: doc/BRIEF.md
# Posted Write Redelivery Controller

This block sits on the target side of a bus bridge. It tracks one buffered posted write at a time and steers how the write is redelivered when the target ends an attempt early. A new posted write is loaded with its start address, its command and its length in DWORDs. After each delivery attempt the bus side reports how the attempt ended and how many DWORDs the target accepted. The block then produces the start address, command and remaining length for the next attempt. It also raises status-bit set pulses and a system error request when a write cannot be delivered.

The restart address depends on how the attempt ended. A retry restarts from the same address. A disconnect restarts from the first DWORD that was not delivered. An invalidate-type write that was partly delivered continues as a plain memory write, because the remaining burst no longer covers a whole cache line. Attempts are counted. When the limit is reached the write is discarded, and a system error is raised if two configuration bits allow it.

Top module: `pw_redeliver_ctrl`

## Requirements
- R1: After reset `busy`, `drop_pulse`, `rx_tabort_set`, `sig_serr_set` and `serr_req` are all 0.
- R2: When the block is idle, a `load_valid` with a nonzero `load_dwords` captures the address, command and length, and `busy` is 1 on the next cycle. A load with zero length, or any load while `busy` is 1, is ignored.
- R3: An attempt that ends with termination code 1 (retry) leaves `nxt_addr`, `nxt_cmd` and `nxt_left` unchanged.
- R4: An attempt that ends with code 2 (disconnect), or with code 0 (normal) with data still left, adds 4×accepted to `nxt_addr` and subtracts accepted from `nxt_left`. The accepted count is clipped to the remaining count.
- R5: The command encoding is 2'b01 for memory write and 2'b11 for memory-write-and-invalidate. If the command is 2'b11 and an attempt accepts at least one DWORD but not all of them, `nxt_cmd` becomes 2'b01.
- R6: When an attempt with code 0 or 2 delivers all remaining DWORDs, `busy` clears and `drop_pulse` pulses for one cycle. No status pulse and no `serr_req` is raised.
- R7: An attempt that ends with code 3 (abort) clears `busy` and pulses `drop_pulse` and `rx_tabort_set`. It also pulses `serr_req` and `sig_serr_set` only if `cfg_serr_en` is 1.
- R8: Every attempt that leaves data undelivered counts toward the limit. When the attempt that reaches `ATTEMPT_LIMIT` fails, `busy` clears and `drop_pulse` pulses. `serr_req` and `sig_serr_set` pulse only if `cfg_serr_en` is 1 and `cfg_nodeliv_dis` is 0.
- R9: The attempt count restarts from zero on every accepted load.
- R10: `att_done` while idle changes no output and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_valid | input | 1 | Load a new posted write |
| load_addr | input | AW | Start byte address of the new write |
| load_cmd | input | 2 | Command of the new write (01 write, 11 write-and-invalidate) |
| load_dwords | input | CW | Length of the new write in DWORDs |
| att_done | input | 1 | One attempt has ended this cycle |
| att_term | input | 2 | How the attempt ended: 0 normal, 1 retry, 2 disconnect, 3 abort |
| att_dwords | input | CW | DWORDs accepted by the target in this attempt |
| cfg_serr_en | input | 1 | System error reporting enable |
| cfg_nodeliv_dis | input | 1 | Suppresses the error for a write that could not be delivered |
| busy | output | 1 | A posted write is pending delivery |
| nxt_addr | output | AW | Start address for the next attempt |
| nxt_cmd | output | 2 | Command for the next attempt |
| nxt_left | output | CW | DWORDs still to deliver |
| drop_pulse | output | 1 | The write has left the buffer (one cycle) |
| rx_tabort_set | output | 1 | Set pulse for the received-target-abort status bit |
| sig_serr_set | output | 1 | Set pulse for the signaled-system-error status bit |
| serr_req | output | 1 | System error request pulse |

## Verification
The hardest state to reach is the last allowed attempt. A write must survive exactly `ATTEMPT_LIMIT` - 1 failed attempts with partial progress along the way. The next failure must then land with each of the four combinations of the two configuration bits. The bench builds the design with a limit of 4. It drives trains of single-DWORD disconnects and retries across write lengths that end just before, exactly at, and after the limit. A bench-side arithmetic model decides for each attempt whether it completes the write, fails it or gives up.

// File: rtl/pwr_pkg.sv
// Shared encodings for the posted write redelivery controller.
package pwr_pkg;
    typedef enum logic [1:0] {
        TERM_NORMAL = 2'd0,
        TERM_RETRY  = 2'd1,
        TERM_DISC   = 2'd2,
        TERM_ABORT  = 2'd3
    } term_e;

    localparam logic [1:0] CMD_MW  = 2'b01;
    localparam logic [1:0] CMD_MWI = 2'b11;
endpackage

// File: rtl/pwr_attempt_ctr.sv
// Counts failed delivery attempts of the current posted write.
// Assumes clear and bump are never both set; 'last' flags that the next
// failure reaches LIMIT attempts. LIMIT must be at least 2.
module pwr_attempt_ctr #(
    parameter int LIMIT = 1 << 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bump,
    output logic last
);
    localparam int CTRW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
    localparam logic [CTRW-1:0] LAST_VAL = CTRW'(LIMIT - 1);

    logic [CTRW-1:0] cnt_q;

    // Count failed attempts; restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (bump && !last) cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == LAST_VAL);
endmodule

// File: rtl/pwr_addr_track.sv
// Holds the start address, command and remaining length of the pending write.
// On advance, moves past the accepted DWORDs (assumed already clipped) and
// downgrades an invalidate command after a partial delivery.
module pwr_addr_track
    import pwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic [1:0]    load_cmd,
    input  logic [CW-1:0] load_dwords,
    input  logic          advance,
    input  logic [CW-1:0] adv_dwords,
    output logic [AW-1:0] addr,
    output logic [1:0]    cmd,
    output logic [CW-1:0] left
);
    logic partial;

    assign partial = (adv_dwords != '0) && (adv_dwords < left);

    // Track the restart point of the pending write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            cmd  <= CMD_MW;
            left <= '0;
        end else if (load) begin
            addr <= load_addr;
            cmd  <= load_cmd;
            left <= load_dwords;
        end else if (advance) begin
            addr <= addr + (AW'(adv_dwords) << 2);
            left <= left - adv_dwords;
            if (partial && cmd == CMD_MWI) cmd <= CMD_MW;
        end
    end
endmodule

// File: rtl/pwr_err_gate.sv
// Decides which status and error pulses follow from an ending write.
// Purely combinational; the top registers the results.
module pwr_err_gate (
    input  logic abort_ev,
    input  logic limit_ev,
    input  logic serr_en,
    input  logic nodeliv_dis,
    output logic rx_tabort,
    output logic serr
);
    // Abort reports when enabled; give-up also honours the non-delivery disable.
    always_comb begin
        rx_tabort = abort_ev;
        serr      = (abort_ev && serr_en) || (limit_ev && serr_en && !nodeliv_dis);
    end
endmodule

// File: rtl/pw_redeliver_ctrl.sv
// Posted write redelivery controller: one pending write, per-attempt
// termination handling, attempt limit and error escalation.
// Assumes att_done is a one-cycle pulse per attempt and that att_dwords is
// zero on a retry (it is ignored then).
module pw_redeliver_ctrl
    import pwr_pkg::*;
#(
    parameter int AW            = 32,
    parameter int CW            = 16,
    parameter int ATTEMPT_LIMIT = 1 << 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_valid,
    input  logic [AW-1:0] load_addr,
    input  logic [1:0]    load_cmd,
    input  logic [CW-1:0] load_dwords,
    input  logic          att_done,
    input  logic [1:0]    att_term,
    input  logic [CW-1:0] att_dwords,
    input  logic          cfg_serr_en,
    input  logic          cfg_nodeliv_dis,
    output logic          busy,
    output logic [AW-1:0] nxt_addr,
    output logic [1:0]    nxt_cmd,
    output logic [CW-1:0] nxt_left,
    output logic          drop_pulse,
    output logic          rx_tabort_set,
    output logic          sig_serr_set,
    output logic          serr_req
);
    term_e         term;
    logic          load_ok, att, is_abort, moved, finishing, failed, give_up, end_xfer;
    logic [CW-1:0] acc_clip;
    logic          ctr_last, g_rx, g_serr;

    assign term = term_e'(att_term);

    // Decode the current attempt outcome.
    always_comb begin
        load_ok   = !busy && load_valid && (load_dwords != '0);
        att       = busy && att_done;
        is_abort  = att && (term == TERM_ABORT);
        moved     = att && (term == TERM_NORMAL || term == TERM_DISC);
        acc_clip  = (att_dwords > nxt_left) ? nxt_left : att_dwords;
        finishing = moved && (acc_clip == nxt_left);
        failed    = att && !is_abort && !finishing;
        give_up   = failed && ctr_last;
        end_xfer  = is_abort || finishing || give_up;
    end

    pwr_attempt_ctr #(.LIMIT(ATTEMPT_LIMIT)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load_ok),
        .bump  (failed),
        .last  (ctr_last)
    );

    pwr_addr_track #(.AW(AW), .CW(CW)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load_ok),
        .load_addr   (load_addr),
        .load_cmd    (load_cmd),
        .load_dwords (load_dwords),
        .advance     (moved),
        .adv_dwords  (acc_clip),
        .addr        (nxt_addr),
        .cmd         (nxt_cmd),
        .left        (nxt_left)
    );

    pwr_err_gate u_gate (
        .abort_ev    (is_abort),
        .limit_ev    (give_up),
        .serr_en     (cfg_serr_en),
        .nodeliv_dis (cfg_nodeliv_dis),
        .rx_tabort   (g_rx),
        .serr        (g_serr)
    );

    // Pending flag and registered one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            drop_pulse    <= 1'b0;
            rx_tabort_set <= 1'b0;
            sig_serr_set  <= 1'b0;
            serr_req      <= 1'b0;
        end else begin
            if (load_ok) busy <= 1'b1;
            else if (end_xfer) busy <= 1'b0;
            drop_pulse    <= end_xfer;
            rx_tabort_set <= g_rx;
            sig_serr_set  <= g_serr;
            serr_req      <= g_serr;
        end
    end
endmodule

// Property checker bound to the controller.
module pwr_checker
    import pwr_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          load_valid,
    input logic [AW-1:0] load_addr,
    input logic [CW-1:0] load_dwords,
    input logic          att_done,
    input logic [1:0]    att_term,
    input logic [CW-1:0] att_dwords,
    input logic          cfg_serr_en,
    input logic          busy,
    input logic [AW-1:0] nxt_addr,
    input logic [1:0]    nxt_cmd,
    input logic [CW-1:0] nxt_left,
    input logic          serr_req,
    input logic          drop_pulse
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && load_valid && load_dwords != '0) |=> (busy && nxt_addr == $past(load_addr)));
    // R3
    retry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && att_done && att_term == TERM_RETRY) |=> ($stable(nxt_addr) && $stable(nxt_left)));
    // R5
    mwi_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && att_done && att_term == TERM_DISC && att_dwords != '0 &&
         att_dwords < nxt_left && nxt_cmd == CMD_MWI) |=> (nxt_cmd == CMD_MW));
    // R7
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && att_done && att_term == TERM_ABORT && !load_valid) |=> (!busy && drop_pulse));
    // R8
    serr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_req |-> $past(cfg_serr_en));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_valid) |=> (!busy && !serr_req && !drop_pulse));
endmodule

bind pw_redeliver_ctrl pwr_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_valid  (load_valid),
    .load_addr   (load_addr),
    .load_dwords (load_dwords),
    .att_done    (att_done),
    .att_term    (att_term),
    .att_dwords  (att_dwords),
    .cfg_serr_en (cfg_serr_en),
    .busy        (busy),
    .nxt_addr    (nxt_addr),
    .nxt_cmd     (nxt_cmd),
    .nxt_left    (nxt_left),
    .serr_req    (serr_req),
    .drop_pulse  (drop_pulse)
);

// File: tb/sim_pw_redeliver_ctrl.sv
module sim_pw_redeliver_ctrl;
    localparam int PERIOD = 10;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int LIM = 4;
    localparam logic [1:0] MW = 2'b01, MWI = 2'b11;

    logic clk = 0, rst_n = 0;
    logic load_valid = 0, att_done = 0, cfg_serr_en = 0, cfg_nodeliv_dis = 0;
    logic [AW-1:0] load_addr = '0;
    logic [1:0] load_cmd = MW, att_term = 0;
    logic [CW-1:0] load_dwords = '0, att_dwords = '0;
    logic busy, drop_pulse, rx_tabort_set, sig_serr_set, serr_req;
    logic [AW-1:0] nxt_addr;
    logic [1:0] nxt_cmd;
    logic [CW-1:0] nxt_left;

    int total = 0, bad = 0;
    bit e_busy = 0;
    logic [AW-1:0] e_addr = '0;
    logic [1:0] e_cmd = MW;
    int e_left = 0, e_cnt = 0;

    always #(PERIOD/2) clk = ~clk;

    pw_redeliver_ctrl #(.AW(AW), .CW(CW), .ATTEMPT_LIMIT(LIM)) u0 (.*);

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_all(string req, bit drop, bit rx, bit serr);
        chk(req, "busy", busy, e_busy);
        chk(req, "addr", nxt_addr, e_addr);
        chk(req, "cmd", nxt_cmd, e_cmd);
        chk(req, "left", nxt_left, e_left);
        chk(req, "drop", drop_pulse, drop);
        chk(req, "rx_tabort", rx_tabort_set, rx);
        chk(req, "serr", serr_req, serr);
        chk(req, "sig_serr", sig_serr_set, serr);
    endtask

    task automatic do_load(logic [AW-1:0] a, logic [1:0] c, int n);
        @(negedge clk);
        load_valid = 1; load_addr = a; load_cmd = c; load_dwords = CW'(n);
        @(negedge clk);
        load_valid = 0;
        if (!e_busy && n != 0) begin
            e_busy = 1; e_addr = a; e_cmd = c; e_left = n; e_cnt = 0;
        end
        chk("R2", "load", 0, 0);
        chk_all("R2", 0, 0, 0);
    endtask

    task automatic attempt(int term, int acc);
        bit drop = 0, rx = 0, serr = 0, fail = 0;
        string req = "R10";
        @(negedge clk);
        att_done = 1; att_term = 2'(term); att_dwords = CW'(acc);
        @(negedge clk);
        att_done = 0; att_dwords = '0;
        if (e_busy) begin
            if (term == 3) begin
                req = "R7"; e_busy = 0; drop = 1; rx = 1; serr = cfg_serr_en;
            end else if (term == 1) begin
                req = "R3"; fail = 1;
            end else begin
                int a = (acc > e_left) ? e_left : acc;
                req = "R4";
                if (a > 0 && a < e_left && e_cmd == MWI) begin e_cmd = MW; req = "R5"; end
                e_addr = e_addr + AW'(4 * a);
                if (a == e_left) begin req = "R6"; e_busy = 0; drop = 1; end
                else fail = 1;
                e_left = e_left - a;
            end
            if (fail) begin
                if (e_cnt == LIM - 1) begin
                    req = "R8"; e_busy = 0; drop = 1;
                    serr = cfg_serr_en && !cfg_nodeliv_dis;
                end else e_cnt++;
            end
        end
        chk_all(req, drop, rx, serr);
    endtask

    initial begin
        #(PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk_all("R1", 0, 0, 0);
        // R2 zero length ignored, R10 idle attempts ignored
        do_load(16'h0040, MW, 0);
        for (int t = 0; t < 4; t++) attempt(t, 2);
        // Sweep lengths, commands and configs through disconnect trains (R4 R5 R8)
        for (int cfg = 0; cfg < 4; cfg++) begin
            cfg_serr_en = cfg[0]; cfg_nodeliv_dis = cfg[1];
            for (int n = 1; n <= 7; n++) begin
                for (int c = 0; c < 2; c++) begin
                    do_load(AW'(16'h0100 * n + 8), c ? MWI : MW, n);
                    while (e_busy) attempt(2, 1);
                end
            end
            // Retry trains to the limit (R3 R8), with counter clear between loads (R9)
            do_load(16'h2000, MWI, 5);
            for (int k = 0; k < LIM - 1; k++) attempt(1, 0);
            attempt(0, 9);
            do_load(16'h3000, MWI, 5);
            for (int k = 0; k < LIM - 1; k++) attempt(1, 0);
            chk("R9", "busy after reload", busy, 1);
            attempt(1, 0);
            // Abort (R7) and load while busy ignored (R2)
            do_load(16'h4000, MW, 3);
            do_load(16'h5550, MWI, 2);
            attempt(2, 2);
            attempt(3, 0);
            // Normal with partial data, then full completion (R4 R6)
            do_load(16'h6000, MWI, 6);
            attempt(0, 2);
            attempt(2, 0);
            attempt(0, 4);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule